// File: doc/BRIEF.md
# Ten-Bit Word Serializer with Internal Loopback

This block turns a stream of 10-bit words, already line-coded upstream, into a non-return-to-zero serial bit stream. It runs entirely on the bit clock. A word counter divides that clock by ten and raises `word_tick` for one cycle in every ten. The word on `word_in` is captured at the edge where `word_tick` is high. Bits then leave one per cycle, least significant first, and the next word follows with no gap.

A loopback control decides where the stream goes. When loopback is off, the stream appears on `line_out`, the receive source `rx_src` follows the external pin `rx_pin`, and `lpbk_out` stays at 0. When loopback is on, the stream appears on `lpbk_out` and is also selected onto `rx_src`, and `line_out` is parked at 0. A protocol device can use this mode to check its own receive path against what it sent.

Top module: `ser10_top`

## Requirements
- R1: A synchronous, active-high `rst` leaves `line_out` and `lpbk_out` at 0 and `word_tick` at 1 in the first cycle after the reset edge, so the first capture happens at the first edge with `rst` low.
- R2: `word_tick` is high for exactly one cycle in every `WORD_W` (10) cycles.
- R3: `word_in` is captured only at an edge where `word_tick` is high. Changes to `word_in` in any other cycle have no effect on the serial stream.
- R4: In cycle k after a capture edge (k = 0 to 9), the stream carries bit k of the captured word. The first bit of the next word follows bit 9 directly.
- R5: With `lpbk_en` = 0, `line_out` carries the stream and `lpbk_out` is 0.
- R6: With `lpbk_en` = 1, `lpbk_out` carries the stream and `line_out` is held at 0.
- R7: `rx_src` equals the stream when `lpbk_en` = 1, and equals `rx_pin` when `lpbk_en` = 0.
- R8: Asserting `rst` in the middle of a word drops both serial outputs to 0 at the next edge and restarts the word count from a capture cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | WORD_W | Parallel word to send, bit 0 first |
| lpbk_en | input | 1 | 1 steers the stream internally and parks the line |
| rx_pin | input | 1 | External serial receive input |
| word_tick | output | 1 | High in the cycle whose closing edge captures `word_in` |
| line_out | output | 1 | External serial output |
| lpbk_out | output | 1 | Internal loopback serial output |
| rx_src | output | 1 | Serial source selected for the receiver |

## Verification
A word counter that is off by one shows up within ten cycles: the tick spacing and every recovered word are wrong in their bit alignment. A shift register that loads at the wrong edge, or that shifts the wrong way, corrupts the first word recovered after reset. A wrong steering decision shows at once, either as activity on the parked output or as `rx_src` disagreeing with the selected source in the same cycle. Because the recovered words are rebuilt from the pins, these faults show up within one word time.

// File: rtl/ser10_pkg.sv
package ser10_pkg;

  localparam int unsigned SER_WORD_W = 10;

  // Next value of a counter that wraps at n.
  function automatic int unsigned wrap_next(int unsigned c, int unsigned n);
    return (c + 1 >= n) ? 0 : c + 1;
  endfunction

  // Capture happens when the count sits at zero.
  function automatic bit is_capture(int unsigned c);
    return c == 0;
  endfunction

endpackage

// File: rtl/ser10_wordctr.sv
module ser10_wordctr #(
  parameter int unsigned WORD_W = ser10_pkg::SER_WORD_W
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= CW'(ser10_pkg::wrap_next(int'(cnt), WORD_W));
  end

  assign tick = ser10_pkg::is_capture(int'(cnt));
endmodule

// File: rtl/ser10_shifter.sv
module ser10_shifter #(
  parameter int unsigned WORD_W = ser10_pkg::SER_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic              cur_bit,
  output logic              next_bit
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (load) sh <= din;
    else           sh <= {1'b0, sh[WORD_W-1:1]};
  end

  assign cur_bit  = sh[0];
  assign next_bit = sh[1];
endmodule

// File: rtl/ser10_lbmux.sv
module ser10_lbmux (
  input  logic ser_bit,
  input  logic lpbk_en,
  input  logic rx_pin,
  output logic line_out,
  output logic lpbk_out,
  output logic rx_src
);
  always_comb begin
    line_out = lpbk_en ? 1'b0 : ser_bit;
    lpbk_out = lpbk_en ? ser_bit : 1'b0;
    rx_src   = lpbk_en ? ser_bit : rx_pin;
  end
endmodule

// File: rtl/ser10_top.sv
module ser10_top #(
  parameter int unsigned WORD_W = ser10_pkg::SER_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  input  logic              lpbk_en,
  input  logic              rx_pin,
  output logic              word_tick,
  output logic              line_out,
  output logic              lpbk_out,
  output logic              rx_src
);
  // Named internal events, used by the bound checker.
  logic load_evt;
  logic ser_bit;
  logic next_bit;

  ser10_wordctr #(.WORD_W(WORD_W)) u_ctr (
    .clk (clk),
    .rst (rst),
    .tick(load_evt)
  );

  ser10_shifter #(.WORD_W(WORD_W)) u_sh (
    .clk     (clk),
    .rst     (rst),
    .load    (load_evt),
    .din     (word_in),
    .cur_bit (ser_bit),
    .next_bit(next_bit)
  );

  ser10_lbmux u_mux (
    .ser_bit (ser_bit),
    .lpbk_en (lpbk_en),
    .rx_pin  (rx_pin),
    .line_out(line_out),
    .lpbk_out(lpbk_out),
    .rx_src  (rx_src)
  );

  assign word_tick = load_evt;
endmodule

// File: rtl/ser10_chk.sv
module ser10_chk #(
  parameter int unsigned WORD_W = ser10_pkg::SER_WORD_W
) (
  input logic clk,
  input logic rst,
  input logic word_lsb,
  input logic lpbk_en,
  input logic rx_pin,
  input logic word_tick,
  input logic line_out,
  input logic lpbk_out,
  input logic rx_src,
  input logic ser_bit,
  input logic next_bit
);
  localparam int unsigned GW = $clog2(WORD_W) + 1;

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      if (word_tick && seen)
        p_tick_gap_r2: assert (gap == GW'(WORD_W - 1));
      gap  <= word_tick ? '0 : gap + 1'b1;
      seen <= seen | word_tick;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (line_out == 1'b0 && lpbk_out == 1'b0 && word_tick));

  p_single_tick_r2: assert property (@(posedge clk) disable iff (rst)
    word_tick |=> !word_tick);

  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    word_tick |=> (ser_bit == $past(word_lsb)));

  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    !word_tick |=> (ser_bit == $past(next_bit)));

  p_lpbk_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !lpbk_en |-> (lpbk_out == 1'b0 && line_out == ser_bit));

  p_line_park_r6: assert property (@(posedge clk) disable iff (rst)
    lpbk_en |-> (line_out == 1'b0 && lpbk_out == ser_bit));

  p_rx_select_r7: assert property (@(posedge clk) disable iff (rst)
    rx_src == (lpbk_en ? lpbk_out : rx_pin));
endmodule

bind ser10_top ser10_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .word_lsb (word_in[0]),
  .lpbk_en  (lpbk_en),
  .rx_pin   (rx_pin),
  .word_tick(word_tick),
  .line_out (line_out),
  .lpbk_out (lpbk_out),
  .rx_src   (rx_src),
  .ser_bit  (ser_bit),
  .next_bit (next_bit)
);

// File: tb/sim_ser10_top.sv
`timescale 1ns/1ps
module sim_ser10_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] word_in;
  logic         lpbk_en;
  logic         rx_pin;
  logic         word_tick, line_out, lpbk_out, rx_src;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  ser10_top #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .word_in(word_in), .lpbk_en(lpbk_en),
    .rx_pin(rx_pin), .word_tick(word_tick), .line_out(line_out),
    .lpbk_out(lpbk_out), .rx_src(rx_src)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Send one word and rebuild it from the selected output, LSB first.
  task automatic send_word(input logic [W-1:0] w, input bit lb, input bit scramble);
    logic [W-1:0] rec;
    int quiet_err;
    int rx_err;
    rec = '0;
    quiet_err = 0;
    rx_err = 0;
    lpbk_en = lb;
    while (!word_tick) @(negedge clk);
    word_in = w;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (scramble && i < W - 1) word_in = (w ^ 10'h3FF) ^ 10'(i);
      rec[i] = lb ? lpbk_out : line_out;
      if ((lb ? line_out : lpbk_out) != 1'b0) quiet_err++;
      if (lb && rx_src != lpbk_out) rx_err++;
    end
    // R4: bits recovered in order, R3: scrambled input ignored
    chk(rec == w, scramble ? "R3 capture only on tick" : "R4 lsb-first word",
        int'(rec), int'(w));
    chk(quiet_err == 0, lb ? "R6 line parked" : "R5 loopback quiet", quiet_err, 0);
    if (lb) chk(rx_err == 0, "R7 rx_src follows stream", rx_err, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; word_in = '0; lpbk_en = 1'b0; rx_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(line_out == 1'b0, "R1 line_out after reset", line_out, 0);
    chk(lpbk_out == 1'b0, "R1 lpbk_out after reset", lpbk_out, 0);
    chk(word_tick == 1'b1, "R1 tick after reset", word_tick, 1);
    rst = 1'b0;
  endtask

  task automatic t_tick_spacing();
    int n;
    while (!word_tick) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!word_tick);
      chk(n == W, "R2 tick spacing", n, W);
    end
  endtask

  task automatic t_normal();
    send_word(10'h17C, 1'b0, 1'b0);
    send_word(10'h3FF, 1'b0, 1'b0);
    send_word(10'h000, 1'b0, 1'b0);
    send_word(10'h2AA, 1'b0, 1'b0);
    send_word(10'h155, 1'b0, 1'b0);
    send_word(10'h201, 1'b0, 1'b1);
  endtask

  task automatic t_loopback();
    send_word(10'h283, 1'b1, 1'b0);
    send_word(10'h3FF, 1'b1, 1'b0);
    send_word(10'h0F0, 1'b1, 1'b1);
  endtask

  task automatic t_rx_pin();
    int err;
    err = 0;
    lpbk_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      rx_pin = i[0];
      #1;
      if (rx_src != rx_pin) err++;
      @(negedge clk);
    end
    chk(err == 0, "R7 rx_src follows rx_pin", err, 0);
    rx_pin = 1'b0;
  endtask

  task automatic t_mid_reset();
    word_in = 10'h3FF;
    lpbk_en = 1'b0;
    while (!word_tick) @(negedge clk);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    word_in = '0;
    @(negedge clk);
    chk(line_out == 1'b0, "R8 line_out cleared mid-word", line_out, 0);
    chk(word_tick == 1'b1, "R8 count restarted", word_tick, 1);
    rst = 1'b0;
    send_word(10'h1E3, 1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_tick_spacing();
    t_normal();
    t_loopback();
    t_rx_pin();
    t_normal();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule